// File: doc/BRIEF.md
# Fast A20 Gate and Processor Reset Control

This block watches host I/O writes on three fixed ports and drives the A20 address-gate output and the active-low processor reset. The writes decoded are the keyboard data port (0x60), the keyboard command port (0x64) and the system control port (0x92). A write counts only while the DMA address-enable input is low, because a high level marks a DMA cycle rather than a host I/O cycle.

Two sources can open the A20 gate. The first is the keyboard-controller path. The host writes the output-port command byte 0xD1 to the command port, and its next write to the data port loads the gate from data bit 1. The whole sequence is recognised in hardware, with no microcontroller in the loop. The second is a two-bit system control register at port 0x92. Its bit 1 forces the gate open. A rising write of its bit 0 fires a fixed-length reset pulse, which is merged with the reset request from the keyboard microcontroller.

The system control register can be disabled. While it is disabled, writes to it are dropped and it reads a fixed filler value.

Top module: `a20_rst_ctrl`

## Requirements
- R1: A write is decoded only when `aen` is low and the full 16-bit address equals exactly 0x60, 0x64 or 0x92. Any other write, including one whose address differs only in the upper byte, has no effect on any output.
- R2: A write of 0xD1 to 0x64 arms the sequence. The next write to 0x60 loads the keyboard gate from data bit 1 and disarms. The new gate value is visible on `a20_gate` after the clock edge that samples the data write.
- R3: A write to 0x64 of any value other than 0xD1 disarms the sequence. A write to 0x60 while the sequence is not armed leaves the keyboard gate unchanged.
- R4: `a20_gate` is the OR of the keyboard gate and bit 1 of the system control register. Either source at 1 drives the output high.
- R5: A write to 0x92 that changes bit 0 from 0 to 1 drives `cpu_rst_n` low for exactly 16 clocks, starting after the sampling edge. A write that leaves bit 0 at 1 starts no pulse.
- R6: While `p92_en` is 1, `p92_rdata` reads {2'b00, 1'b1, 1'b0, 2'b00, bit1, bit0}, where bit1 and bit0 are the values last written (for example 0x20, 0x21, 0x22). While `p92_en` is 0, it reads 0xFF.
- R7: While `p92_en` is 0, writes to 0x92 change neither the register, `a20_gate` nor `cpu_rst_n`.
- R8: `cpu_rst_n` is low whenever `kbc_rst_n` is low or the reset pulse is active.
- R9: After reset, the keyboard gate, the register bits and the armed state are 0. `a20_gate` is then 0, `cpu_rst_n` follows `kbc_rst_n`, and `p92_rdata` reads 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| aen | input | 1 | DMA address enable; high blocks all decoding |
| io_wr | input | 1 | Host I/O write strobe, one cycle per write |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host I/O write data |
| p92_en | input | 1 | Enables the system control register at 0x92 |
| kbc_rst_n | input | 1 | Active-low reset request from the keyboard microcontroller |
| a20_gate | output | 1 | A20 gate, high to pass address line 20 |
| cpu_rst_n | output | 1 | Combined active-low processor reset |
| p92_rdata | output | 8 | Read value of the system control register |

## Verification
Every register update takes effect at the edge that samples `io_wr`. `a20_gate`, `p92_rdata` and the start of the reset pulse are therefore due one edge after a write. The bench drives each write on a falling edge, drops the strobe on the next falling edge, and checks the outputs right there. The reset pulse is checked as low at that point and on each of the following 15 falling edges, then as high on the 16th. Changes on `kbc_rst_n` reach `cpu_rst_n` without a register and are checked after a short settle delay in the same cycle.

// File: rtl/a20_pkg.sv
package a20_pkg;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned NUM_PORTS   = 3;
  localparam int unsigned PORT_DATA   = 0;
  localparam int unsigned PORT_CMD    = 1;
  localparam int unsigned PORT_SYS    = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 16'h0060;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 16'h0064;
  localparam logic [ADDR_W-1:0] ADDR_SYS  = 16'h0092;
  localparam logic [DATA_W-1:0] CMD_WR_OUTPORT = 8'hD1;
  localparam int unsigned GATE_BIT    = 1;
  localparam int unsigned PULSE_LEN   = 16;
  localparam logic [DATA_W-1:0] SYS_RD_DISABLED = 8'hFF;
endpackage

// File: rtl/a20_decode.sv
module a20_decode
  import a20_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NP = NUM_PORTS,
  parameter logic [NP*AW-1:0] PORT_MAP = {ADDR_SYS, ADDR_CMD, ADDR_DATA}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          aen,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  output logic [NP-1:0] wr_hit
);
  logic bus_ok;
  assign bus_ok = io_wr & ~aen;

  for (genvar g = 0; g < NP; g++) begin : g_port
    assign wr_hit[g] = bus_ok & (io_addr == PORT_MAP[g*AW +: AW]);
  end

  assert_single_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
  assert_aen_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> (wr_hit == '0));
endmodule

// File: rtl/a20_kbc_seq.sv
module a20_kbc_seq
  import a20_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter logic [DW-1:0] ARM_CODE = CMD_WR_OUTPORT,
  parameter int unsigned GB = GATE_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic          wr_data,
  input  logic [DW-1:0] wdata,
  output logic          kbc_gate
);
  logic armed_q, armed_d;
  logic gate_q, gate_d;

  always_comb begin
    armed_d = armed_q;
    gate_d  = gate_q;
    if (wr_cmd) begin
      armed_d = (wdata == ARM_CODE);
    end else if (wr_data) begin
      if (armed_q) gate_d = wdata[GB];
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      gate_q  <= gate_d;
    end
  end

  assign kbc_gate = gate_q;

  assert_other_cmd_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata != ARM_CODE) |=> !armed_q);
  assert_unarmed_data_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !armed_q) |=> $stable(gate_q));
  assert_armed_data_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && armed_q && !wr_cmd) |=> (gate_q == $past(wdata[GB])) && !armed_q);
endmodule

// File: rtl/a20_sysctl.sv
module a20_sysctl
  import a20_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned LEN = PULSE_LEN,
  parameter logic [DW-1:0] RD_OFF = SYS_RD_DISABLED
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_sys,
  input  logic [DW-1:0] wdata,
  output logic          force_gate,
  output logic          alt_rst_n,
  output logic [DW-1:0] rdata
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [1:0]    bits_q, bits_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_ok, fire;

  assign wr_ok = wr_sys & en;
  assign fire  = wr_ok & wdata[0] & ~bits_q[0];

  always_comb begin
    bits_d = bits_q;
    if (wr_ok) bits_d = wdata[1:0];
  end

  always_comb begin
    if (fire)             cnt_d = CW'(LEN);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= 2'b00;
      cnt_q  <= '0;
    end else begin
      bits_q <= bits_d;
      cnt_q  <= cnt_d;
    end
  end

  assign force_gate = bits_q[1];
  assign alt_rst_n  = (cnt_q == '0);

  always_comb begin
    rdata = RD_OFF;
    if (en) begin
      rdata      = '0;
      rdata[5]   = 1'b1;
      rdata[1:0] = bits_q;
    end
  end

  assert_fire_starts_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !alt_rst_n);
  assert_pulse_counts_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !fire) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  assert_disabled_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sys && !en) |=> $stable(bits_q));
endmodule

// File: rtl/a20_rst_ctrl.sv
module a20_rst_ctrl
  import a20_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned LEN = PULSE_LEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          aen,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          p92_en,
  input  logic          kbc_rst_n,
  output logic          a20_gate,
  output logic          cpu_rst_n,
  output logic [DW-1:0] p92_rdata
);
  localparam int unsigned NP = NUM_PORTS;

  logic [NP-1:0] wr_hit;
  logic          kbc_gate, force_gate, alt_rst_n;

  a20_decode #(.AW(AW), .NP(NP)) u_decode (
    .clk(clk), .rst_n(rst_n), .aen(aen), .io_wr(io_wr),
    .io_addr(io_addr), .wr_hit(wr_hit)
  );

  a20_kbc_seq #(.DW(DW)) u_kbc (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_hit[PORT_CMD]),
    .wr_data(wr_hit[PORT_DATA]), .wdata(io_wdata), .kbc_gate(kbc_gate)
  );

  a20_sysctl #(.DW(DW), .LEN(LEN)) u_sys (
    .clk(clk), .rst_n(rst_n), .en(p92_en), .wr_sys(wr_hit[PORT_SYS]),
    .wdata(io_wdata), .force_gate(force_gate), .alt_rst_n(alt_rst_n),
    .rdata(p92_rdata)
  );

  assign a20_gate  = kbc_gate | force_gate;
  assign cpu_rst_n = kbc_rst_n & alt_rst_n;
endmodule

// File: tb/a20_rst_ctrl_tb_top.sv
`timescale 1ns/1ps
module a20_rst_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, aen, io_wr, p92_en, kbc_rst_n;
  logic [15:0] io_addr;
  logic [7:0] io_wdata, p92_rdata;
  logic       a20_gate, cpu_rst_n;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  a20_rst_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .aen(aen), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .p92_en(p92_en), .kbc_rst_n(kbc_rst_n),
    .a20_gate(a20_gate), .cpu_rst_n(cpu_rst_n), .p92_rdata(p92_rdata)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Drives one write on a falling edge; returns on the next falling edge,
  // after the sampling rising edge, where registered results are due.
  task automatic host_wr(logic [15:0] a, logic [7:0] d, logic blk = 1'b0);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1; aen = blk;
    @(negedge clk);
    io_wr = 1'b0; aen = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R9 a20 after reset", {7'd0, a20_gate}, 8'd0);
    chk("R9 cpu_rst_n after reset", {7'd0, cpu_rst_n}, 8'd1);
    chk("R9 rdata after reset", p92_rdata, 8'h20);
  endtask

  task automatic t_aen_and_addr();
    host_wr(16'h0064, 8'hD1, 1'b1);
    host_wr(16'h0060, 8'h02, 1'b1);
    chk("R1 aen high blocks sequence", {7'd0, a20_gate}, 8'd0);
    host_wr(16'h0164, 8'hD1);
    host_wr(16'h0060, 8'h02);
    chk("R1 upper-byte alias of 0x64 not decoded", {7'd0, a20_gate}, 8'd0);
    host_wr(16'h0192, 8'h02);
    chk("R1 alias of 0x92 not decoded", p92_rdata, 8'h20);
  endtask

  task automatic t_kbc_path();
    host_wr(16'h0064, 8'hD1);
    host_wr(16'h0060, 8'h02);
    chk("R2 D1 then data bit1=1 opens gate", {7'd0, a20_gate}, 8'd1);
    host_wr(16'h0060, 8'h00);
    chk("R3 second data write after disarm ignored", {7'd0, a20_gate}, 8'd1);
    host_wr(16'h0064, 8'hD1);
    host_wr(16'h0060, 8'hFD);
    chk("R2 D1 then data bit1=0 closes gate", {7'd0, a20_gate}, 8'd0);
  endtask

  task automatic t_cancel();
    host_wr(16'h0064, 8'hD1);
    host_wr(16'h0064, 8'hD0);
    host_wr(16'h0060, 8'h02);
    chk("R3 other command cancels arm", {7'd0, a20_gate}, 8'd0);
    host_wr(16'h0060, 8'h02);
    chk("R3 unarmed data write ignored", {7'd0, a20_gate}, 8'd0);
  endtask

  task automatic t_sys_gate();
    host_wr(16'h0092, 8'h02);
    chk("R4 sys bit1 opens gate", {7'd0, a20_gate}, 8'd1);
    chk("R6 readback 0x22", p92_rdata, 8'h22);
    chk("R5 no pulse for bit0=0", {7'd0, cpu_rst_n}, 8'd1);
    host_wr(16'h0064, 8'hD1);
    host_wr(16'h0060, 8'h02);
    host_wr(16'h0092, 8'h00);
    chk("R4 keyboard gate alone keeps gate open", {7'd0, a20_gate}, 8'd1);
    host_wr(16'h0064, 8'hD1);
    host_wr(16'h0060, 8'h00);
    chk("R4 both sources 0 closes gate", {7'd0, a20_gate}, 8'd0);
  endtask

  task automatic t_pulse();
    host_wr(16'h0092, 8'h01);
    chk("R5 pulse low at first cycle", {7'd0, cpu_rst_n}, 8'd0);
    chk("R6 readback 0x21", p92_rdata, 8'h21);
    for (int i = 1; i < 16; i++) begin
      @(negedge clk);
      chk($sformatf("R5 pulse low cycle %0d", i), {7'd0, cpu_rst_n}, 8'd0);
    end
    @(negedge clk);
    chk("R5 pulse ends after 16 clocks", {7'd0, cpu_rst_n}, 8'd1);
    host_wr(16'h0092, 8'h01);
    chk("R5 rewrite of 1 fires no pulse", {7'd0, cpu_rst_n}, 8'd1);
    host_wr(16'h0092, 8'h00);
  endtask

  task automatic t_kbc_reset();
    @(negedge clk);
    kbc_rst_n = 1'b0;
    #1;
    chk("R8 keyboard reset drives cpu reset", {7'd0, cpu_rst_n}, 8'd0);
    kbc_rst_n = 1'b1;
    #1;
    chk("R8 cpu reset released", {7'd0, cpu_rst_n}, 8'd1);
  endtask

  task automatic t_disabled();
    @(negedge clk);
    p92_en = 1'b0;
    #1;
    chk("R6 disabled reads FF", p92_rdata, 8'hFF);
    host_wr(16'h0092, 8'h03);
    chk("R7 disabled write no gate", {7'd0, a20_gate}, 8'd0);
    chk("R7 disabled write no pulse", {7'd0, cpu_rst_n}, 8'd1);
    @(negedge clk);
    p92_en = 1'b1;
    #1;
    chk("R7 register unchanged after disabled write", p92_rdata, 8'h20);
  endtask

  initial begin
    rst_n = 1'b0; aen = 1'b0; io_wr = 1'b0; io_addr = '0; io_wdata = '0;
    p92_en = 1'b1; kbc_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_aen_and_addr();
    t_kbc_path();
    t_cancel();
    t_sys_gate();
    t_pulse();
    t_kbc_reset();
    t_disabled();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule